// File: doc/BRIEF.md
# Phased RGB Blink-and-Fade PWM Engine

This block drives the three current-sink switches of one RGB LED group. Each colour channel takes a 4-bit brightness (duty), a 4-bit fade rate (slope) and a pair of 4-bit codes that place its turn-on and turn-off points within a repeating blink cycle. A shared blink-length select, a master run bit, an internal-PWM enable, a flash-mode enable, per-channel switch bits and per-channel external-PWM enables complete the settings. The output is one active-high "sink on" bit per channel.

All timing is counted in microsecond ticks supplied by a prescaler outside the block. In normal mode the PWM period has three equal phases, and each colour may conduct only inside its own phase, so at most one LED draws current at any time. In flash mode all channels pulse together and the period shrinks to a single phase. Brightness fades toward the blink target one duty step at a time. An external PWM pin can gate any selected channel on top of the internal duty.

Top module: `rgb_blink_pwm`

## Requirements
- R1: While reset is asserted, every `sink_on` bit is 0. Reset clears all phase, blink and fade counters.
- R2: While `rgb_start` is 0, every `sink_on` bit is 0 from the next clock on. When it is set again, the blink cycle restarts at slot 0 and every faded duty restarts at 0.
- R3: With `int_pwm_en` = 0 and `rgb_start` = 1, `sink_on[i]` equals `sw_en[i]` (subject to R12). Duty, fade and blink settings have no effect.
- R4: In normal mode (`flash_en` = 0) the period is 3×PHASE_US ticks. Phase 0 belongs to red (channel 0, bits [3:0] of each code bus), phase 1 to green (bits [7:4]) and phase 2 to blue (bits [11:8]). No two channels are on in the same cycle.
- R5: Within its phase, a channel with effective duty d is on for the ticks t = 0..PHASE_US-1 that satisfy 15·t < d·PHASE_US. Code 0 is always off and code 15 covers the whole phase (27 ticks for d = 8 and 10 ticks for d = 3, with PHASE_US = 50).
- R6: With `flash_en` = 1, all three channels use the same phase and the period is PHASE_US ticks. The on-time per period follows R5.
- R7: The blink cycle has 16 slots. Each slot lasts SIXTEENTH_US × 2^`cycle_sel` ticks, so 00, 01, 10 and 11 select 1×, 2×, 4× and 8× the base length.
- R8: With on code N ≠ off code M, the fade target is the duty while the slot s lies in [N, M) taken circularly (N ≤ s < M when N < M; s ≥ N or s < M when N > M). Otherwise the target is 0.
- R9: With on = off = 0, the channel runs at its duty at once and for as long as it is enabled. The slope code has no effect.
- R10: With on = off ≠ 0, the channel is held off.
- R11: The effective duty starts at 0 and moves one step toward the target every (slope+1)·SLOPE_UNIT_US ticks. It never changes by more than one step per clock, so the fade time grows with both the slope code and the duty target.
- R12: When `ext_pwm_en[i]` = 1 and `ext_pwm_pin` = 0, `sink_on[i]` is 0. With the pin at 1, the internal result is passed through unchanged.
- R13: In internal-PWM mode, a channel whose `sw_en` bit is 0 stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle microsecond timing strobe |
| rgb_start | input | 1 | Master run; clearing turns all off, setting restarts the blink cycle |
| int_pwm_en | input | 1 | 1: duty/fade/blink engine, 0: direct switch control |
| flash_en | input | 1 | All channels share one phase |
| cycle_sel | input | 2 | Blink cycle length select |
| sw_en | input | 3 | Per-channel switch enable |
| ext_pwm_en | input | 3 | Per-channel external PWM gating enable |
| ext_pwm_pin | input | 1 | External PWM level |
| duty | input | 12 | 4-bit duty per channel |
| slope | input | 12 | 4-bit fade rate per channel |
| on_code | input | 12 | 4-bit turn-on slot per channel |
| off_code | input | 12 | 4-bit turn-off slot per channel |
| sink_on | output | 3 | Per-channel sink switch on |

## Verification
`sink_on` is registered, so a change at an input or counter shows up one clock later. The direct-mode, stop and gating results are therefore compared on every cycle after a settling clock. Duty and phase results are counted over a full period window, which gives the same total whatever the phase alignment. Blink and fade results are due at slot boundaries that fall several hundred cycles after `rgb_start`. Each of those checks opens its window tens of cycles after the boundary plus the longest fade, so the slot and ramp positions are settled.

// File: rtl/rgbp_pkg.sv
package rgbp_pkg;
    localparam int NCH    = 3;
    localparam int CODE_W = 4;
    localparam int DMAX   = (1 << CODE_W) - 1;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [NCH-1:0] sink;
    } out_st_t;
endpackage

// File: rtl/rgbp_timebase.sv
module rgbp_timebase #(
    parameter int PHASE_US      = 50,
    parameter int SIXTEENTH_US  = 15625,
    parameter int SLOPE_UNIT_US = 2067,
    localparam int PH_W  = $clog2(PHASE_US + 1),
    localparam int SUB_W = $clog2(SIXTEENTH_US * 8 + 1),
    localparam int UN_W  = $clog2(SLOPE_UNIT_US + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             run,
    input  logic             flash,
    input  logic [1:0]       cycle_sel,
    output logic [PH_W-1:0]  phase_cnt,
    output logic [1:0]       phase_idx,
    output logic [3:0]       slot,
    output logic             slope_tick
);
    typedef struct packed {
        logic [PH_W-1:0]  pcnt;
        logic [1:0]       pidx;
        logic [SUB_W-1:0] sub;
        logic [3:0]       slot;
        logic [UN_W-1:0]  unit;
        logic             stick;
    } tb_st_t;

    tb_st_t st_d, st_q;
    int     sub_lim;

    always_comb begin
        st_d       = st_q;
        st_d.stick = 1'b0;
        sub_lim    = (SIXTEENTH_US << cycle_sel) - 1;
        if (!run) begin
            st_d = '0;
        end else if (us_tick) begin
            if (int'(st_q.pcnt) >= PHASE_US - 1) begin
                st_d.pcnt = '0;
                if (flash)               st_d.pidx = 2'd0;
                else if (st_q.pidx >= 2) st_d.pidx = 2'd0;
                else                     st_d.pidx = st_q.pidx + 2'd1;
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
            if (int'(st_q.sub) >= sub_lim) begin
                st_d.sub  = '0;
                st_d.slot = st_q.slot + 4'd1;
            end else begin
                st_d.sub  = st_q.sub + 1'b1;
            end
            if (int'(st_q.unit) >= SLOPE_UNIT_US - 1) begin
                st_d.unit  = '0;
                st_d.stick = 1'b1;
            end else begin
                st_d.unit  = st_q.unit + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_cnt  = st_q.pcnt;
    assign phase_idx  = st_q.pidx;
    assign slot       = st_q.slot;
    assign slope_tick = st_q.stick;

    p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase_cnt) < PHASE_US) && (phase_idx <= 2'd2));

    p_slot_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (slot == $past(slot) || slot == $past(slot) + 4'd1));

    p_halt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (slot == 4'd0 && phase_cnt == '0));
endmodule

// File: rtl/rgbp_window.sv
module rgbp_window
    import rgbp_pkg::*;
(
    input  code_t      on_c,
    input  code_t      off_c,
    input  logic [3:0] slot,
    output logic       steady,
    output logic       lit
);
    always_comb begin
        steady = (on_c == '0) && (off_c == '0);
        if (on_c == off_c)     lit = 1'b0;
        else if (on_c < off_c) lit = (slot >= on_c) && (slot < off_c);
        else                   lit = (slot >= on_c) || (slot < off_c);
    end
endmodule

// File: rtl/rgbp_ramp.sv
module rgbp_ramp
    import rgbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  slope_tick,
    input  code_t target,
    input  code_t rate,
    output code_t cur
);
    typedef struct packed {
        code_t lvl;
        code_t wait_cnt;
    } rp_st_t;

    rp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (st_q.lvl == target) begin
            st_d.wait_cnt = '0;
        end else if (slope_tick) begin
            if (st_q.wait_cnt >= rate) begin
                st_d.wait_cnt = '0;
                if (st_q.lvl < target) st_d.lvl = st_q.lvl + 1'b1;
                else                   st_d.lvl = st_q.lvl - 1'b1;
            end else begin
                st_d.wait_cnt = st_q.wait_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur = st_q.lvl;

    p_single_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cur == $past(cur) || cur == $past(cur) + 1'b1 || cur == $past(cur) - 1'b1));

    p_hold_at_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cur == target) |=> $stable(cur));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cur == '0));
endmodule

// File: rtl/rgb_blink_pwm.sv
module rgb_blink_pwm
    import rgbp_pkg::*;
#(
    parameter int PHASE_US      = 50,
    parameter int SIXTEENTH_US  = 15625,
    parameter int SLOPE_UNIT_US = 2067,
    localparam int PH_W   = $clog2(PHASE_US + 1),
    localparam int BUS_W  = NCH * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             rgb_start,
    input  logic             int_pwm_en,
    input  logic             flash_en,
    input  logic [1:0]       cycle_sel,
    input  logic [NCH-1:0]   sw_en,
    input  logic [NCH-1:0]   ext_pwm_en,
    input  logic             ext_pwm_pin,
    input  logic [BUS_W-1:0] duty,
    input  logic [BUS_W-1:0] slope,
    input  logic [BUS_W-1:0] on_code,
    input  logic [BUS_W-1:0] off_code,
    output logic [NCH-1:0]   sink_on
);
    logic [PH_W-1:0] phase_cnt;
    logic [1:0]      phase_idx;
    logic [3:0]      slot;
    logic            slope_tick;
    logic            eng_run;

    logic [NCH-1:0]  steady;
    logic [NCH-1:0]  lit;
    code_t           eff   [NCH];
    code_t           faded [NCH];

    out_st_t out_d, out_q;

    assign eng_run = rgb_start && int_pwm_en;

    rgbp_timebase #(
        .PHASE_US      (PHASE_US),
        .SIXTEENTH_US  (SIXTEENTH_US),
        .SLOPE_UNIT_US (SLOPE_UNIT_US)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .run        (eng_run),
        .flash      (flash_en),
        .cycle_sel  (cycle_sel),
        .phase_cnt  (phase_cnt),
        .phase_idx  (phase_idx),
        .slot       (slot),
        .slope_tick (slope_tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        code_t ch_duty, ch_target;
        assign ch_duty   = duty[g*CODE_W +: CODE_W];
        assign ch_target = lit[g] ? ch_duty : '0;

        rgbp_window u_window (
            .on_c   (on_code[g*CODE_W +: CODE_W]),
            .off_c  (off_code[g*CODE_W +: CODE_W]),
            .slot   (slot),
            .steady (steady[g]),
            .lit    (lit[g])
        );

        rgbp_ramp u_ramp (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (eng_run && !steady[g]),
            .slope_tick (slope_tick),
            .target     (ch_target),
            .rate       (slope[g*CODE_W +: CODE_W]),
            .cur        (faded[g])
        );

        assign eff[g] = steady[g] ? ch_duty : faded[g];

        p_equal_codes_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (eng_run && on_code[g*CODE_W +: CODE_W] == off_code[g*CODE_W +: CODE_W]
             && on_code[g*CODE_W +: CODE_W] != '0) |=> !sink_on[g]);
    end

    always_comb begin
        out_d = '0;
        for (int i = 0; i < NCH; i++) begin
            logic in_phase, pulse, base, gate;
            in_phase = flash_en || (int'(phase_idx) == i);
            pulse    = in_phase && ((int'(phase_cnt) * DMAX) < (int'(eff[i]) * PHASE_US));
            base     = int_pwm_en ? pulse : 1'b1;
            gate     = !(ext_pwm_en[i] && !ext_pwm_pin);
            out_d.sink[i] = rgb_start && sw_en[i] && base && gate;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sink_on = out_q.sink;

    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (sink_on == '0));

    p_stop_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_start |=> (sink_on == '0));

    p_direct_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_start && !int_pwm_en && ext_pwm_en == '0) |=> (sink_on == $past(sw_en)));

    p_one_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run && !flash_en) |=> ($countones(sink_on) <= 1));

    p_ext_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_pwm_pin |=> ((sink_on & $past(ext_pwm_en)) == '0));

    p_switch_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sink_on & ~$past(sw_en)) == '0));
endmodule

// File: tb/rgb_blink_pwm_bench.sv
module rgb_blink_pwm_bench;
    localparam int PH  = 50;
    localparam int SIX = 300;
    localparam int SU  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b1;
    logic        rgb_start = 1'b0;
    logic        int_pwm_en = 1'b0;
    logic        flash_en = 1'b0;
    logic [1:0]  cycle_sel = 2'b00;
    logic [2:0]  sw_en = 3'b000;
    logic [2:0]  ext_pwm_en = 3'b000;
    logic        ext_pwm_pin = 1'b1;
    logic [11:0] duty = '0;
    logic [11:0] slope = '0;
    logic [11:0] on_code = '0;
    logic [11:0] off_code = '0;
    logic [2:0]  sink_on;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int t0 = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rgb_blink_pwm #(
        .PHASE_US (PH), .SIXTEENTH_US (SIX), .SLOPE_UNIT_US (SU)
    ) u_rgb_blink_pwm (
        .clk (clk), .rst_n (rst_n), .us_tick (us_tick), .rgb_start (rgb_start),
        .int_pwm_en (int_pwm_en), .flash_en (flash_en), .cycle_sel (cycle_sel),
        .sw_en (sw_en), .ext_pwm_en (ext_pwm_en), .ext_pwm_pin (ext_pwm_pin),
        .duty (duty), .slope (slope), .on_code (on_code), .off_code (off_code),
        .sink_on (sink_on)
    );

    function automatic int on_ticks(input int d);
        int n = 0;
        for (int t = 0; t < PH; t++) if (15 * t < d * PH) n++;
        return n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_mid(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act <= lo || act >= hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected strictly between %0d and %0d", req, act, lo, hi);
        end
    endtask

    task automatic measure(input int n, output int c0, output int c1, output int c2, output int multi);
        c0 = 0; c1 = 0; c2 = 0; multi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            c0 += int'(sink_on[0]);
            c1 += int'(sink_on[1]);
            c2 += int'(sink_on[2]);
            if ($countones(sink_on) > 1) multi++;
        end
    endtask

    task automatic at(input int k);
        while (cyc < t0 + k) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        rgb_start = 1'b0;
        repeat (3) @(negedge clk);
        rgb_start = 1'b1;
        t0 = cyc;
    endtask

    task automatic t_reset();
        int c0, c1, c2, m;
        sw_en = 3'b111; int_pwm_en = 1'b0; rgb_start = 1'b1;
        measure(5, c0, c1, c2, m);
        chk("R1 reset holds outputs off", c0 + c1 + c2, 0);
        rgb_start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_direct();
        int c0, c1, c2, m;
        int_pwm_en = 1'b0; sw_en = 3'b101; duty = '0; ext_pwm_en = '0;
        on_code = 12'h555; off_code = 12'h555;
        restart();
        @(negedge clk);
        measure(20, c0, c1, c2, m);
        chk("R3 direct red", c0, 20);
        chk("R3 direct green", c1, 0);
        chk("R3 direct blue", c2, 20);
        ext_pwm_en = 3'b001; ext_pwm_pin = 1'b0;
        @(negedge clk);
        measure(20, c0, c1, c2, m);
        chk("R12 gated red off", c0, 0);
        chk("R12 ungated blue on", c2, 20);
        ext_pwm_pin = 1'b1;
        @(negedge clk);
        measure(10, c0, c1, c2, m);
        chk("R12 pin high passes red", c0, 10);
        ext_pwm_en = '0;
        rgb_start = 1'b0;
        @(negedge clk);
        measure(10, c0, c1, c2, m);
        chk("R2 stop turns all off", c0 + c1 + c2, 0);
    endtask

    task automatic t_phases();
        int c0, c1, c2, m;
        int_pwm_en = 1'b1; flash_en = 1'b0; sw_en = 3'b111;
        on_code = '0; off_code = '0; slope = 12'hFFF;
        duty = {4'd3, 4'd8, 4'd15};
        restart();
        at(5);
        measure(3 * PH, c0, c1, c2, m);
        chk("R5 R9 red duty 15", c0, on_ticks(15));
        chk("R5 R9 green duty 8", c1, on_ticks(8));
        chk("R5 R9 blue duty 3", c2, on_ticks(3));
        chk("R4 no phase overlap", m, 0);
        duty = {4'd3, 4'd0, 4'd15};
        @(negedge clk);
        measure(3 * PH, c0, c1, c2, m);
        chk("R5 duty 0 stays off", c1, 0);
        duty = {4'd3, 4'd8, 4'd15};
        sw_en = 3'b101;
        @(negedge clk);
        measure(3 * PH, c0, c1, c2, m);
        chk("R13 switch off gates green", c1, 0);
        chk("R13 switch on keeps red", c0, on_ticks(15));
        sw_en = 3'b111;
        flash_en = 1'b1;
        repeat (2 * PH) @(negedge clk);
        measure(PH, c0, c1, c2, m);
        chk("R6 flash red", c0, on_ticks(15));
        chk("R6 flash green", c1, on_ticks(8));
        chk("R6 flash blue", c2, on_ticks(3));
        flash_en = 1'b0;
    endtask

    task automatic t_blink();
        int c0, c1, c2, m;
        int_pwm_en = 1'b1; sw_en = 3'b111; cycle_sel = 2'b00;
        duty = 12'hFFF; slope = 12'h000;
        on_code  = {4'd5, 4'd12, 4'd4};
        off_code = {4'd5, 4'd3,  4'd8};
        restart();
        at(350);  measure(150, c0, c1, c2, m);
        chk("R8 red before on slot", c0, 0);
        chk("R8 green wrapped window", c1, 50);
        chk("R10 blue equal codes slot1", c2, 0);
        at(1850); measure(150, c0, c1, c2, m);
        chk("R8 red inside window", c0, 50);
        chk("R8 green after off", c1, 0);
        chk("R10 blue equal codes slot6", c2, 0);
        at(3050); measure(150, c0, c1, c2, m);
        chk("R8 red after off", c0, 0);
        at(3700); measure(150, c0, c1, c2, m);
        chk("R8 green reopens at slot 12", c1, 50);
        restart();
        at(1850); measure(150, c0, c1, c2, m);
        chk("R2 restart from slot zero red", c0, 50);
        chk("R2 restart from slot zero green", c1, 0);
    endtask

    task automatic t_cycle();
        int c0, c1, c2, m;
        int_pwm_en = 1'b1; sw_en = 3'b001; duty = 12'h00F; slope = '0;
        on_code = 12'h001; off_code = 12'h000;
        cycle_sel = 2'b01;
        restart();
        at(350);  measure(150, c0, c1, c2, m);
        chk("R7 sel01 slot1 not yet", c0, 0);
        at(750);  measure(150, c0, c1, c2, m);
        chk("R7 sel01 slot1 reached", c0, 50);
        cycle_sel = 2'b11;
        restart();
        at(1000); measure(150, c0, c1, c2, m);
        chk("R7 sel11 slot1 not yet", c0, 0);
        at(2500); measure(150, c0, c1, c2, m);
        chk("R7 sel11 slot1 reached", c0, 50);
        cycle_sel = 2'b00;
    endtask

    task automatic t_ramp();
        int c0, c1, c2, m;
        int_pwm_en = 1'b1; sw_en = 3'b011; cycle_sel = 2'b00;
        duty = {4'd0, 4'd7, 4'd15}; slope = 12'h0FF;
        on_code = 12'h011; off_code = 12'h000;
        restart();
        at(620);  measure(150, c0, c1, c2, m);
        chk_mid("R11 red mid fade", c0, 0, 50);
        at(820);  measure(150, c0, c1, c2, m);
        chk("R11 green duty 7 fade done", c1, on_ticks(7));
        at(1400); measure(150, c0, c1, c2, m);
        chk("R11 red fade done", c0, 50);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_phases();
        t_blink();
        t_cycle();
        t_ramp();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule